// File: doc/BRIEF.md
# Protection Entry Register Bank

This block stores the machine-mode control state for eight memory-protection entries. Each entry has an 8-bit configuration and a 32-bit address word. The address word carries bits 33:2 of the physical address. Software reaches this state through one CSR read/write port that only honours machine-mode accesses. A write first passes through the legal-value rules and is then stored. An entry that is locked stays frozen until reset. A locked top-of-range entry also protects the address word of the entry just below it.

The address word is read back through a grain of 2^(G+2) bytes, where G is set by the `GRAIN_G` parameter. Software can therefore discover G: it clears the configuration of entry 0, writes all ones to address 0, reads it back and finds the lowest set bit. Both outputs go to the access checker. `cfg_out` carries the stored configurations. `addr_out` carries the address words as they read back.

Top module: `prot_cfg_bank`

## Requirements
- R1: After reset, every configuration byte reads 0 (mode off, unlocked) and every address word reads 0.
- R2: An access with `csr_priv` other than 2'b11 (machine) changes no state, and `csr_rdata` reads 0 for it.
- R3: Register map on `csr_addr`: value 0 holds entries 0–3 and value 1 holds entries 4–7, with entry 4k+j in bits 8j+7:8j. Values 8+i select the address word of entry i. All other values read 0 and ignore writes. In a configuration byte, bit 0 is read, bit 1 is write, bit 2 is execute, bits 4:3 are the mode (0 off, 1 top-of-range, 2 four-byte, 3 power-of-two) and bit 7 is the lock. Bits 6:5 always read 0.
- R4: A byte that writes read=0 with write=1 leaves that entry's three permission bits unchanged and updates its other fields. The pair read=0, write=1 is never stored.
- R5: When G ≥ 1, a write of mode 2 is stored as mode 0.
- R6: While an entry's lock is set, writes to its configuration byte and to its address word are ignored. Other bytes of the same configuration register are still written.
- R7: While entry i+1 is locked with mode 1, writes to address word i are ignored. A locked entry i+1 in any other mode does not protect word i.
- R8: A lock set with mode 0 still locks the entry. Only reset clears a lock.
- R9: With G ≥ 1, an address word whose entry is in mode 0 or 1 reads with bits G−1:0 as zero.
- R10: With G ≥ 2, an address word whose entry is in mode 3 reads with bits G−2:0 as ones.
- R11: After entry 0's configuration is written to 0 and address word 0 to all ones, the lowest set bit of address word 0 on readback is G.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_en | input | 1 | Access valid this cycle |
| csr_we | input | 1 | Access is a write |
| csr_priv | input | 2 | Privilege of the access, 2'b11 is machine |
| csr_addr | input | 4 | Register select |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data, combinational |
| cfg_out | output | 64 | Stored configuration bytes, entry i in bits 8i+7:8i |
| addr_out | output | 256 | Address words as read back, entry i in bits 32i+31:32i |

## Verification
A single configuration write can set the lock of one entry while it legalizes the fields of the same byte and of its neighbours. The bench provokes this with locking bytes that also carry reserved permissions or mode 2. It also places a locked top-of-range entry beside unlocked ones in the same register. Each case is judged by reading back every byte and address word and comparing it against an arithmetic model of the write rules. The model also applies the lock and neighbour-protection rules to later writes, and every outcome is compared against it.

// File: rtl/prot_cfg_bank.sv
module prot_cfg_bank #(
  parameter int GRAIN_G = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         csr_en,
  input  logic         csr_we,
  input  logic [1:0]   csr_priv,
  input  logic [3:0]   csr_addr,
  input  logic [31:0]  csr_wdata,
  output logic [31:0]  csr_rdata,
  output logic [63:0]  cfg_out,
  output logic [255:0] addr_out
);
  localparam int N = 8;
  localparam logic [31:0] LOWZ = 32'((64'd1 << GRAIN_G) - 64'd1);
  localparam logic [31:0] LOWO = (GRAIN_G >= 1) ? 32'(((64'd1 << GRAIN_G) >> 1) - 64'd1) : 32'd0;

  logic [N-1:0][7:0]  cfg_w;
  logic [N-1:0][31:0] addr_w;
  logic [N-1:0][31:0] view_w;

  wire acc    = csr_en && (csr_priv == 2'b11);
  wire wr     = acc && csr_we;
  wire is_cfg = (csr_addr[3:1] == 3'b000);

  for (genvar i = 0; i < N; i++) begin : g_e
    logic [7:0]  c_q, c_nx;
    logic [31:0] a_q;
    logic        prot;
    wire  [7:0]  wb      = csr_wdata[8*(i%4) +: 8];
    wire         cfg_hit = wr && is_cfg && (csr_addr[0] == ((i / 4) == 1));
    wire         adr_hit = wr && csr_addr[3] && (csr_addr[2:0] == 3'(i));

    if (i < N - 1) begin : g_nb
      assign prot = cfg_w[i+1][7] && (cfg_w[i+1][4:3] == 2'b01);
    end else begin : g_last
      assign prot = 1'b0;
    end

    always_comb begin
      c_nx      = {wb[7], 2'b00, wb[4:3], wb[2:0]};
      if (wb[1:0] == 2'b10) c_nx[2:0] = c_q[2:0];
      if (GRAIN_G >= 1 && wb[4:3] == 2'b10) c_nx[4:3] = 2'b00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        c_q <= '0;
        a_q <= '0;
      end else begin
        if (cfg_hit && !c_q[7]) c_q <= c_nx;
        if (adr_hit && !c_q[7] && !prot) a_q <= csr_wdata;
      end
    end

    assign cfg_w[i]  = c_q;
    assign addr_w[i] = a_q;
    assign view_w[i] = !c_q[4] ? (a_q & ~LOWZ) :
                       (c_q[3] ? (a_q | LOWO) : a_q);

    a_r4_no_reserved_rwx: assert property (@(posedge clk) disable iff (!rst_n)
      c_q[1:0] != 2'b10);
    a_r3_gap_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
      c_q[6:5] == 2'b00);
    a_r5_no_na4_stored: assert property (@(posedge clk) disable iff (!rst_n)
      (GRAIN_G >= 1) |-> (c_q[4:3] != 2'b10));
    a_r8_lock_sticks: assert property (@(posedge clk) disable iff (!rst_n)
      c_q[7] |=> c_q[7]);
    a_r6_locked_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      c_q[7] |=> ($stable(c_q) && $stable(a_q)));
    a_r7_tor_guard: assert property (@(posedge clk) disable iff (!rst_n)
      prot |=> $stable(a_q));
  end

  always_comb begin
    csr_rdata = '0;
    if (acc) begin
      if (csr_addr[3])  csr_rdata = view_w[csr_addr[2:0]];
      else if (is_cfg)  csr_rdata = csr_addr[0] ? cfg_w[7:4] : cfg_w[3:0];
    end
  end

  assign cfg_out  = cfg_w;
  assign addr_out = view_w;

  a_r2_low_priv_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_en && csr_priv != 2'b11) |=> ($stable(cfg_w) && $stable(addr_w)));
  a_r2_low_priv_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_en && csr_priv != 2'b11) |-> (csr_rdata == 32'd0));
endmodule

// File: tb/prot_cfg_bank_bench.sv
`timescale 1ns/1ps
module prot_cfg_bank_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic csr_en = 1'b0, csr_we = 1'b0;
  logic [1:0] csr_priv = 2'b11;
  logic [3:0] csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic [63:0] cfg_out;
  logic [255:0] addr_out;

  int checks = 0, errors = 0;
  logic [7:0]  mcfg [8];
  logic [31:0] maddr [8];

  prot_cfg_bank #(.GRAIN_G(2)) u_prot_cfg_bank (
    .clk(clk), .rst_n(rst_n), .csr_en(csr_en), .csr_we(csr_we), .csr_priv(csr_priv),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .cfg_out(cfg_out), .addr_out(addr_out));

  always #2 clk = ~clk;

  function automatic logic [7:0] legal(logic [7:0] old, logic [7:0] w);
    logic [2:0] p = (w[1:0] == 2'b10) ? old[2:0] : w[2:0];
    logic [1:0] m = (w[4:3] == 2'b10) ? 2'b00 : w[4:3];
    return {w[7], 2'b00, m, p};
  endfunction

  function automatic logic [31:0] view(int i);
    if (mcfg[i][4:3] == 2'b11) return maddr[i] | 32'h1;
    return maddr[i] & ~32'h3;
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) begin mcfg[i] = '0; maddr[i] = '0; end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d, logic [1:0] p = 2'b11);
    @(negedge clk);
    csr_en = 1'b1; csr_we = 1'b1; csr_priv = p; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_en = 1'b0; csr_we = 1'b0; csr_priv = 2'b11;
    if (p == 2'b11) begin
      if (a[3:1] == 3'b000)
        for (int j = 0; j < 4; j++) begin
          int e = 4 * a[0] + j;
          if (!mcfg[e][7]) mcfg[e] = legal(mcfg[e], d[8*j +: 8]);
        end
      else if (a[3]) begin
        int e = a[2:0];
        if (!mcfg[e][7] && !(e < 7 && mcfg[e+1][7] && mcfg[e+1][4:3] == 2'b01))
          maddr[e] = d;
      end
    end
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d, input logic [1:0] p = 2'b11);
    @(negedge clk);
    csr_en = 1'b1; csr_we = 1'b0; csr_priv = p; csr_addr = a;
    #1 d = csr_rdata;
    csr_en = 1'b0; csr_priv = 2'b11;
  endtask

  task automatic check_all(string req);
    logic [31:0] d;
    for (int r = 0; r < 2; r++) begin
      rd(4'(r), d);
      chk(req, d, {mcfg[4*r+3], mcfg[4*r+2], mcfg[4*r+1], mcfg[4*r]});
    end
    for (int i = 0; i < 8; i++) begin
      rd(4'(8 + i), d);
      chk(req, d, view(i));
    end
  endtask

  initial begin
    #(4ns * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    do_reset();
    check_all("R1 reset state");
    rd(4'd5, d); chk("R3 unmapped reads zero", d, 32'd0);

    // R3 R4 R5: sweep of unlocked byte values through both config registers
    for (int r = 0; r < 2; r++)
      for (int v = 0; v < 128; v++) begin
        logic [7:0] b0 = 8'(v), b1 = 8'(v ^ 8'h15) & 8'h7f;
        logic [7:0] b2 = 8'(v + 37) & 8'h7f, b3 = ~8'(v) & 8'h7f;
        wr(4'(r), {b3, b2, b1, b0});
        rd(4'(r), d);
        chk("R4/R5 legalized config (R3 layout)", d,
            {mcfg[4*r+3], mcfg[4*r+2], mcfg[4*r+1], mcfg[4*r]});
      end

    // R2: lower-privilege writes and reads
    wr(4'd0, 32'h0000_0000); wr(4'd1, 32'h0000_0000);
    wr(4'd9, 32'h1234_5678);
    wr(4'd0, 32'h0F0F_0F0F, 2'b01);
    wr(4'd9, 32'hFFFF_FFFF, 2'b00);
    wr(4'd4, 32'hFFFF_FFFF);
    check_all("R2 low-privilege write ignored");
    rd(4'd9, d, 2'b01); chk("R2 low-privilege read zero", d, 32'd0);

    // R9 R10: address view per mode
    for (int i = 0; i < 8; i++)
      for (int m = 0; m < 4; m++) begin
        if (m == 2) continue;
        wr(4'(i / 4), 32'(8'({m[1:0], 3'b001})) << (8 * (i % 4)));
        wr(4'(8 + i), 32'hA5A5_5A5B ^ 32'(i));
        rd(4'(8 + i), d);
        chk(m == 3 ? "R10 napot view" : "R9 off/tor view", d, view(i));
      end

    // R11: granularity discovery
    wr(4'd0, 32'h0); wr(4'd8, 32'hFFFF_FFFF);
    rd(4'd8, d);
    chk("R11 grain readback", d, 32'hFFFF_FFFC);
    chk("R11 lowest set bit is G", 32'($countones(d ^ (d - 1)) - 1), 32'd2);

    // R6 R7 R8: locks, including lock set with reserved fields in the same write
    wr(4'd1, {8'h80, 8'h00, 8'h8A, 8'h03});
    wr(4'd0, {8'h00, 8'h00, 8'h99, 8'h01});
    check_all("R6/R8 lock with reserved fields");
    wr(4'd13, 32'h1111_1111);
    wr(4'd12, 32'h2222_2222);
    wr(4'd14, 32'h3333_3333);
    wr(4'd15, 32'h4444_4444);
    wr(4'd8,  32'h5555_5555);
    wr(4'd9,  32'h6666_6666);
    wr(4'd10, 32'h7777_7777);
    check_all("R7 tor guard on lower word");
    wr(4'd1, 32'h0707_0707);
    wr(4'd0, 32'h0B0B_0B0B);
    check_all("R6 locked bytes kept, others written");
    wr(4'd1, 32'h0);
    rd(4'd1, d); chk("R8 lock survives clear attempt", d & 32'h8000_8000, 32'h8000_8000);

    do_reset();
    check_all("R8 reset clears locks");
    wr(4'd13, 32'hCAFE_F00C);
    rd(4'd13, d); chk("R8 entry writable after reset", d, 32'hCAFE_F00C);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule